// File: doc/BRIEF.md
# Selectable System Clock Divider Controller

This block produces clock enables for the domains of a small microcontroller from one base clock. A control register holds a mode bit and a three-bit select code. With the mode bit clear, a non-zero code slows only the processor, and the peripherals and the clock output keep running at the full base rate. With the mode bit set, the same code divides the rate for every domain together, including the visible clock output.

No derived clock exists. A free-running three-bit counter on the base clock sets the phase, and each domain receives a single-cycle enable pulse once per divided period. The division ratio can be changed while the chip runs. A new setting is loaded only at the counter wrap, so no pulse is cut short or sent twice.

Software must change the mode bit and the select code in separate writes. If one write tries to change both, the block accepts only the new mode bit. The register port is a plain write strobe with a read bus that always shows the register. There is no data stream and so no back-pressure.

Top module: `clkdiv_ctrl`

## Requirements
- R1: After reset, the register reads 0x00, and `cpu_ce`, `per_ce` and `cko_ce` are high in every cycle.
- R2: `rd_data` shows the mode bit at bit 5 and the select code at bits 2..0. Bits 7, 6, 4 and 3 always read 0, and the values written to them are ignored.
- R3: With the mode bit at 0 in effect, `cpu_ce` pulses once every n cycles for the ratio n of the select code. `per_ce` and `cko_ce` stay high in every cycle.
- R4: With the mode bit at 1 in effect, `cpu_ce`, `per_ce` and `cko_ce` all pulse once every n cycles, in the same cycles.
- R5: The select code sets n as follows: 000 gives 1 (full rate), 001 gives 2, 010 gives 4, and 011 through 111 give 8.
- R6: The phase counter is 0 in the first cycle after reset is released and then counts up by one each cycle, modulo 8. A domain with ratio n is enabled in the cycles where counter mod n equals 0. In a cycle where the counter is 0, every enable is high.
- R7: A write whose bit 5 differs from the current mode bit changes only the mode bit, and the select code keeps its old value. Any other write loads bits 2..0 into the select code.
- R8: The setting used during an 8-cycle frame (counter 0 to 7) is the register value held during the cycle in which the counter was 7, just before that frame. A write that lands after that cycle takes effect one frame later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle in which it is high |
| wr_data | input | 8 | Write value |
| rd_data | output | 8 | Current register contents |
| cpu_ce | output | 1 | Processor clock enable |
| per_ce | output | 1 | Peripheral clock enable |
| cko_ce | output | 1 | Clock-output enable |

## Verification
The hardest case to reach is a write that lands in the last cycle of a frame. The register changes at once, but the frame that follows must still run on the old ratio. The bench follows its own phase count and waits until that count reads 7 before it drives a write from divide-by-8 to divide-by-2. It then counts the pulses in the next two frames and expects one pulse and then four. A write that changes the mode bit and the select code together is also driven on purpose, to show that the select code keeps its old value.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int SEL_W    = 3;
  localparam int SHIFT_W  = 2;
  localparam int MODE_POS = 5;
  localparam int DOM_CPU  = 0;
  localparam int DOM_PER  = 1;
  localparam int NUM_DOM  = 2;

  typedef logic [SHIFT_W-1:0] shift_t;

  typedef struct packed {
    logic             whole_chip;
    logic [SEL_W-1:0] code;
  } ctrl_t;

  // select code to log2 of the division ratio
  function automatic shift_t code_to_shift(logic [SEL_W-1:0] code);
    shift_t s;
    case (code)
      3'd0:    s = 2'd0;
      3'd1:    s = 2'd1;
      3'd2:    s = 2'd2;
      default: s = 2'd3;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output ctrl_t         ctrl
);
  localparam logic [DW-1:0] MODE_MASK = DW'(1) << MODE_POS;
  localparam logic [DW-1:0] CODE_MASK = (DW'(1) << SEL_W) - DW'(1);

  logic [DW-1:0] reg_q;
  logic          mode_flip;

  assign mode_flip = (wr_data[MODE_POS] != reg_q[MODE_POS]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
    end else if (wr_en) begin
      if (mode_flip)
        reg_q <= (reg_q & ~MODE_MASK) | (wr_data & MODE_MASK);
      else
        reg_q <= (reg_q & ~CODE_MASK) | (wr_data & CODE_MASK);
    end
  end

  assign rd_data         = reg_q;
  assign ctrl.whole_chip = reg_q[MODE_POS];
  assign ctrl.code       = reg_q[SEL_W-1:0];

  // R7
  code_kept_on_mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_flip) |=> (rd_data[SEL_W-1:0] == $past(rd_data[SEL_W-1:0])));
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  ctrl_t                     ctrl,
  output logic [CNT_W-1:0]          cnt,
  output shift_t [NUM_DOM-1:0]      dom_shift
);
  localparam logic [CNT_W-1:0] LAST = '1;

  logic   frame_end;
  shift_t req_shift;

  assign frame_end = (cnt == LAST);
  assign req_shift = code_to_shift(ctrl.code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_shift <= '0;
    end else if (frame_end) begin
      dom_shift[DOM_CPU] <= req_shift;
      dom_shift[DOM_PER] <= ctrl.whole_chip ? req_shift : '0;
    end
  end

  // R8
  load_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dom_shift) |-> ($past(cnt) == LAST));

  // R3
  cpu_not_faster_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dom_shift[DOM_CPU] >= dom_shift[DOM_PER]);
endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     cnt,
  input  shift_t [NUM_DOM-1:0] dom_shift,
  output logic [NUM_DOM-1:0]   ce
);
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic [CNT_W-1:0] mask;
    assign mask  = (CNT_W'(1) << dom_shift[d]) - CNT_W'(1);
    assign ce[d] = ((cnt & mask) == '0);
  end

  // R6
  all_on_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (&ce));
endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          cpu_ce,
  output logic          per_ce,
  output logic          cko_ce
);
  ctrl_t                ctrl;
  logic [CNT_W-1:0]     cnt;
  shift_t [NUM_DOM-1:0] dom_shift;
  logic [NUM_DOM-1:0]   ce;

  clkdiv_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ctrl(ctrl)
  );

  clkdiv_phase #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .cnt(cnt), .dom_shift(dom_shift)
  );

  clkdiv_gate #(.CNT_W(CNT_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .dom_shift(dom_shift), .ce(ce)
  );

  assign cpu_ce = ce[DOM_CPU];
  assign per_ce = ce[DOM_PER];
  assign cko_ce = ce[DOM_PER];

  // R3
  cpu_implies_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |-> per_ce);
endmodule

// File: tb/clkdiv_ctrl_tb.sv
module clkdiv_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       cpu_ce, per_ce, cko_ce;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model state
  int m_cnt = 0, m_mode = 0, m_sel = 0, m_rcpu = 1, m_rper = 1;

  always #2.5 clk = ~clk;

  clkdiv_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cpu_ce(cpu_ce), .per_ce(per_ce), .cko_ce(cko_ce)
  );

  function automatic int ratio_of(int code);
    if (code == 0) return 1;
    if (code == 1) return 2;
    if (code == 2) return 4;
    return 8;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_mode = 0; m_sel = 0; m_rcpu = 1; m_rper = 1;
    end else begin
      if (m_cnt == 7) begin
        m_rcpu = ratio_of(m_sel);
        m_rper = m_mode ? ratio_of(m_sel) : 1;
      end
      if (wr_en) begin
        if (int'(wr_data[5]) != m_mode) m_mode = int'(wr_data[5]);
        else m_sel = int'(wr_data[2:0]);
      end
      m_cnt = (m_cnt + 1) % 8;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk(rd_data == 8'((m_mode << 5) | m_sel), {cur_req, " rd_data"}, rd_data, (m_mode << 5) | m_sel);
      chk(cpu_ce == ((m_cnt % m_rcpu) == 0), {cur_req, " cpu_ce"}, cpu_ce, (m_cnt % m_rcpu) == 0);
      chk(per_ce == ((m_cnt % m_rper) == 0), {cur_req, " per_ce"}, per_ce, (m_cnt % m_rper) == 0);
      chk(cko_ce == ((m_cnt % m_rper) == 0), {cur_req, " cko_ce"}, cko_ce, (m_cnt % m_rper) == 0);
    end
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(logic [7:0] d);
    @(negedge clk); #1 wr_en = 1'b1; wr_data = d;
    @(negedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_frame(output int nc, output int np);
    nc = 0; np = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      nc += int'(cpu_ce);
      np += int'(per_ce);
    end
  endtask

  initial begin
    int nc, np;
    idle(3);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk(rd_data == 8'h00, "R1 reset rd_data", rd_data, 0);
    chk(cpu_ce && per_ce && cko_ce, "R1 reset enables", {cpu_ce, per_ce, cko_ce}, 7);
    idle(10);

    // R7: mode flip write with other bits set keeps code 000
    cur_req = "R7";
    wr(8'hFF);
    chk(rd_data == 8'h20, "R7 mode-only write", rd_data, 8'h20);
    idle(16);

    // R2: reserved bits ignored
    cur_req = "R2";
    wr(8'h3A);
    chk(rd_data == 8'h22, "R2 reserved bits zero", rd_data, 8'h22);
    cur_req = "R4";
    idle(24);
    count_frame(nc, np);
    chk(nc == 2 && np == 2, "R4 whole-chip div4", nc * 10 + np, 22);

    // R5: code map in whole-chip mode
    cur_req = "R5";
    wr(8'h21); idle(16);
    count_frame(nc, np);
    chk(np == 4, "R5 code 001", np, 4);
    wr(8'h23); idle(16);
    count_frame(nc, np);
    chk(np == 1, "R5 code 011", np, 1);
    wr(8'h24); idle(16);
    wr(8'h27); idle(16);
    count_frame(nc, np);
    chk(nc == 1 && np == 1, "R5 code 111", nc * 10 + np, 11);

    // R7: both fields changed in one write
    cur_req = "R7";
    wr(8'h01);
    chk(rd_data == 8'h07, "R7 code kept", rd_data, 8'h07);

    // R3: processor-only slowdown
    cur_req = "R3";
    idle(16);
    count_frame(nc, np);
    chk(nc == 1 && np == 8, "R3 cpu div8", nc * 10 + np, 18);
    wr(8'h02); idle(16);
    count_frame(nc, np);
    chk(nc == 2 && np == 8, "R3 cpu div4", nc * 10 + np, 28);

    // R8: write in the last cycle of a frame
    cur_req = "R8";
    wr(8'h20); idle(8);
    wr(8'h23); idle(16);
    do @(negedge clk); while (m_cnt != 7);
    #1 wr_en = 1'b1; wr_data = 8'h21;
    @(negedge clk); #1 wr_en = 1'b0;
    chk(rd_data == 8'h21, "R8 register updated", rd_data, 8'h21);
    // now at frame start: next frame still div8, then div2
    nc = int'(cpu_ce);
    for (int i = 0; i < 7; i++) begin @(negedge clk); #1; nc += int'(cpu_ce); end
    chk(nc == 1, "R8 old ratio frame", nc, 1);
    count_frame(nc, np);
    chk(nc == 4 && np == 4, "R8 new ratio frame", nc * 10 + np, 44);

    // R6: all enables high at counter zero
    cur_req = "R6";
    wr(8'h23); idle(16);
    do @(negedge clk); while (m_cnt != 0);
    #1 chk(cpu_ce && per_ce && cko_ce, "R6 counter zero", {cpu_ce, per_ce, cko_ce}, 7);
    idle(4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule